// File: doc/BRIEF.md
# Parallel-Prefix Adder with Logarithmic Sparse Carry Tree

This block adds two operands in pure combinational logic and returns a result one bit wider than the wider operand. The carry-in is fixed at zero. Each bit column first forms a propagate term (operand XOR) and a generate term (operand AND). A sparse valency-2 prefix tree then derives the carry into every column. It does this in two passes. An up-sweep merges neighbouring columns into groups of 2, then 4, then 8 and so on. A down-sweep then fills in the carries for the columns the up-sweep skipped. A final stage XORs each propagate term with its carry to form the sum.

A compile-time switch picks how the operands are read. In unsigned mode the extra top bit is the carry-out. In signed mode the extra top bit extends the two's-complement sign, so the result never overflows. The operand widths may differ. The narrower operand is widened to the larger width before the addition: with zeros in unsigned mode, and with copies of its top bit in signed mode. The block is meant to be dropped into a datapath wherever a shallow adder with low cell fan-out is wanted. Any registering is up to the surrounding logic.

Top module: `bk_adder`

## Requirements
- R1: With SIGNED_MODE=0, sum_o equals the unsigned value of op_a plus the unsigned value of op_b, taken at N+1 bits, where N is the larger of WA and WB. Bit N is the carry-out of the N-bit addition.
- R2: With SIGNED_MODE=1, sum_o equals the two's-complement sum of the operands at N+1 bits. Bit N is the XOR of the two operand sign bits and the carry-out. When the operand signs differ, bit N equals bit N-1.
- R3: When WA and WB differ, the narrower operand is widened to N bits before the addition. In unsigned mode it is zero-filled, and in signed mode it is sign-filled.
- R4: The carry into bit 0 is zero. Two zero operands give a zero result, and sum_o[0] always equals op_a[0] XOR op_b[0].
- R5: The result is correct when N is not a power of two (for example N=6). In that case the tree omits the cells that would cover columns above N-1.
- R6: A carry generated in bit 0 propagates through every column. In unsigned mode, all-ones plus one gives 2^N.
- R7: In signed mode, two most-negative operands give -2^N. Bit N is 1 and bits N-1..0 are 0.
- R8: The smallest width N=2 gives correct results in signed mode for all 16 operand pairs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WA | First operand |
| op_b | input | WB | Second operand |
| sum_o | output | N+1 | Sum; N = max(WA, WB); bit N is the carry-out or the sign extension |

## Verification
The hardest case to reach is a carry that must cross every column. This happens when a generate term appears in the lowest column and every propagate term above it is high. In that case both sweeps of the tree lie on the critical carry path, and a missing or misrouted grey cell shows up only in that column. The 8-bit, 6-bit and 2-bit instances are swept over every operand pair, so every propagate/generate pattern reaches every column. The wide instances with unequal operand widths are driven with random vectors plus hand-picked all-ones, zero and most-negative operands. These hit the long carry chains and the sign-fill of the narrower operand.

// File: rtl/bk_pkg.sv
// Package: shared helpers for the parallel-prefix adder.
// Assumes: widths passed in are at least 1.
package bk_pkg;

    // Number of up-sweep levels needed to span m carry columns
    function automatic int bk_levels(input int m);
        return (m > 1) ? $clog2(m) : 0;
    endfunction

    // Index of the last stage in the prefix array for m columns
    function automatic int bk_last_stage(input int m);
        return (bk_levels(m) == 0) ? 0 : 2 * bk_levels(m) - 1;
    endfunction

endpackage

// File: rtl/bk_grey_cell.sv
// Module: valency-2 grey cell; merges an upper group with a lower
// group that already reaches column 0, so only generate is formed.
// Assumes: the lower generate is a finished prefix.
module bk_grey_cell (
    input  logic gen_hi,
    input  logic prop_hi,
    input  logic gen_lo,
    output logic gen_o
);
    // Group generate of the merged span
    assign gen_o = gen_hi | (prop_hi & gen_lo);
endmodule

// File: rtl/bk_black_cell.sv
// Module: valency-2 black cell; merges two adjacent groups into one,
// forming both group generate and group propagate.
// Assumes: hi and lo groups are contiguous.
module bk_black_cell (
    input  logic gen_hi,
    input  logic prop_hi,
    input  logic gen_lo,
    input  logic prop_lo,
    output logic gen_o,
    output logic prop_o
);
    // Group generate of the merged span
    assign gen_o  = gen_hi | (prop_hi & gen_lo);
    // Group propagate of the merged span
    assign prop_o = prop_hi & prop_lo;
endmodule

// File: rtl/bk_pg_gen.sv
// Module: widens both operands to N bits and forms per-column
// propagate (XOR) and generate (AND) terms.
// Assumes: WA and WB are at least 1; N = max(WA, WB).
module bk_pg_gen #(
    parameter int WA          = 8,
    parameter int WB          = 8,
    parameter bit SIGNED_MODE = 1'b0,
    localparam int N          = (WA > WB) ? WA : WB
) (
    input  logic [WA-1:0] op_a,
    input  logic [WB-1:0] op_b,
    output logic [N-1:0]  prop_o,
    output logic [N-1:0]  gen_o
);
    logic [N-1:0] a_wide;
    logic [N-1:0] b_wide;

    // Widen operand A: copy when already full width, else fill
    if (WA == N) begin : g_a_full
        assign a_wide = op_a;
    end else begin : g_a_ext
        assign a_wide = {{(N-WA){SIGNED_MODE & op_a[WA-1]}}, op_a};
    end

    // Widen operand B: copy when already full width, else fill
    if (WB == N) begin : g_b_full
        assign b_wide = op_b;
    end else begin : g_b_ext
        assign b_wide = {{(N-WB){SIGNED_MODE & op_b[WB-1]}}, op_b};
    end

    // Per-column propagate and generate
    assign prop_o = a_wide ^ b_wide;
    assign gen_o  = a_wide & b_wide;
endmodule

// File: rtl/bk_prefix_tree.sv
// Module: sparse valency-2 prefix tree. An up-sweep builds groups of
// 2, 4, 8 ... columns, then a down-sweep fills in the skipped columns.
// Output pfx_o[j] is the group generate over columns j..0 (carry into j+1).
// Assumes: M >= 1; cells that would cover columns >= M are left out.
module bk_prefix_tree
    import bk_pkg::*;
#(
    parameter int M = 7,
    localparam int L    = bk_levels(M),
    localparam int LAST = bk_last_stage(M)
) (
    input  logic [M-1:0] prop_i,
    input  logic [M-1:0] gen_i,
    output logic [M-1:0] pfx_o
);
    logic [M-1:0] gs [0:LAST];
    logic [M-1:0] ps [0:LAST];

    // Stage 0 is the raw per-column terms
    assign gs[0] = gen_i;
    assign ps[0] = prop_i;

    // Up-sweep: level u merges pairs of groups of width 2^u
    for (genvar u = 0; u < L; u++) begin : g_up
        localparam int SPAN = 1 << u;
        for (genvar j = 0; j < M; j++) begin : g_col
            if (((j + 1) % (2 * SPAN)) == 0) begin : g_cell
                if ((j + 1) == 2 * SPAN) begin : g_grey
                    bk_grey_cell u_gc (
                        .gen_hi (gs[u][j]),
                        .prop_hi(ps[u][j]),
                        .gen_lo (gs[u][j-SPAN]),
                        .gen_o  (gs[u+1][j])
                    );
                    assign ps[u+1][j] = 1'b0;
                end else begin : g_black
                    bk_black_cell u_bc (
                        .gen_hi (gs[u][j]),
                        .prop_hi(ps[u][j]),
                        .gen_lo (gs[u][j-SPAN]),
                        .prop_lo(ps[u][j-SPAN]),
                        .gen_o  (gs[u+1][j]),
                        .prop_o (ps[u+1][j])
                    );
                end
            end else begin : g_pass
                assign gs[u+1][j] = gs[u][j];
                assign ps[u+1][j] = ps[u][j];
            end
        end
    end

    // Down-sweep: level d fans finished prefixes to columns 2^d above
    for (genvar k = 0; k < L - 1; k++) begin : g_down
        localparam int D    = L - 2 - k;
        localparam int SPAN = 1 << D;
        localparam int SRC  = L + k;
        for (genvar j = 0; j < M; j++) begin : g_col
            if ((((j + 1) % (2 * SPAN)) == SPAN) && (j >= 2 * SPAN)) begin : g_grey
                bk_grey_cell u_gc (
                    .gen_hi (gs[SRC][j]),
                    .prop_hi(ps[SRC][j]),
                    .gen_lo (gs[SRC][j-SPAN]),
                    .gen_o  (gs[SRC+1][j])
                );
                assign ps[SRC+1][j] = 1'b0;
            end else begin : g_pass
                assign gs[SRC+1][j] = gs[SRC][j];
                assign ps[SRC+1][j] = ps[SRC][j];
            end
        end
    end

    // Last stage holds a complete prefix for every column
    assign pfx_o = gs[LAST];
endmodule

// File: rtl/bk_sum_stage.sv
// Module: forms sum bits from propagate terms and carries, the
// carry-out via a grey cell, and the top result bit per mode.
// Assumes: N >= 2; pfx_i[j] is the carry into column j+1.
module bk_sum_stage #(
    parameter int N           = 8,
    parameter bit SIGNED_MODE = 1'b0
) (
    input  logic [N-1:0] prop_i,
    input  logic [N-1:0] gen_i,
    input  logic [N-2:0] pfx_i,
    output logic [N:0]   sum_o
);
    logic [N-1:0] carry;
    logic         cout;

    // Carries: zero into column 0, prefixes above
    assign carry = {pfx_i, 1'b0};

    // Carry-out through a final grey cell
    bk_grey_cell u_cout (
        .gen_hi (gen_i[N-1]),
        .prop_hi(prop_i[N-1]),
        .gen_lo (carry[N-1]),
        .gen_o  (cout)
    );

    // Low result bits reuse the propagate XOR
    assign sum_o[N-1:0] = prop_i ^ carry;

    // Top bit: carry-out, or sign extension in signed mode
    if (SIGNED_MODE) begin : g_signed
        assign sum_o[N] = prop_i[N-1] ^ cout;
    end else begin : g_unsigned
        assign sum_o[N] = cout;
    end
endmodule

// File: rtl/bk_adder.sv
// Module: top of the combinational parallel-prefix adder.
// Assumes: max(WA, WB) >= 2; carry-in is fixed at zero; no registers.
module bk_adder #(
    parameter int WA          = 8,
    parameter int WB          = 8,
    parameter bit SIGNED_MODE = 1'b0,
    localparam int N          = (WA > WB) ? WA : WB
) (
    input  logic [WA-1:0] op_a,
    input  logic [WB-1:0] op_b,
    output logic [N:0]    sum_o
);
    logic [N-1:0] prop;
    logic [N-1:0] gen;
    logic [N-2:0] pfx;

    // Per-column terms
    bk_pg_gen #(.WA(WA), .WB(WB), .SIGNED_MODE(SIGNED_MODE)) u_pg (
        .op_a  (op_a),
        .op_b  (op_b),
        .prop_o(prop),
        .gen_o (gen)
    );

    // Carries for columns 1..N-1
    bk_prefix_tree #(.M(N-1)) u_tree (
        .prop_i(prop[N-2:0]),
        .gen_i (gen[N-2:0]),
        .pfx_o (pfx)
    );

    // Sum and top bit
    bk_sum_stage #(.N(N), .SIGNED_MODE(SIGNED_MODE)) u_sum (
        .prop_i(prop),
        .gen_i (gen),
        .pfx_i (pfx),
        .sum_o (sum_o)
    );
endmodule

// File: rtl/bk_adder_chk.sv
// Module: checker bound to bk_adder; compares the result against an
// arithmetic model built from the ports.
// Assumes: purely combinational target, so immediate checks are used.
module bk_adder_chk #(
    parameter int WA          = 8,
    parameter int WB          = 8,
    parameter bit SIGNED_MODE = 1'b0,
    localparam int N          = (WA > WB) ? WA : WB
) (
    input logic [WA-1:0] op_a,
    input logic [WB-1:0] op_b,
    input logic [N:0]    sum_o
);
    logic [N:0] ax;
    logic [N:0] bx;

    // Model operands widened to N+1 bits per mode
    always_comb begin
        ax = {{(N+1-WA){SIGNED_MODE & op_a[WA-1]}}, op_a};
        bx = {{(N+1-WB){SIGNED_MODE & op_b[WB-1]}}, op_b};
    end

    // Port-level checks of the result
    always_comb begin
        // R1 R2 R3
        sum_ref_chk: assert (sum_o == ax + bx)
            else $error("sum mismatch");
        // R4
        lsb_chk: assert (sum_o[0] == (op_a[0] ^ op_b[0]))
            else $error("bit 0 mismatch");
        // R2
        no_overflow_chk: assert (!(SIGNED_MODE && (ax[N-1] != bx[N-1])) || (sum_o[N] == sum_o[N-1]))
            else $error("sign bit mismatch");
        // R1
        zero_cout_chk: assert (SIGNED_MODE || !((ax == '0) || (bx == '0)) || (sum_o[N] == 1'b0))
            else $error("spurious carry-out");
    end
endmodule

bind bk_adder bk_adder_chk #(.WA(WA), .WB(WB), .SIGNED_MODE(SIGNED_MODE)) u_chk (
    .op_a (op_a),
    .op_b (op_b),
    .sum_o(sum_o)
);

// File: tb/bk_adder_test.sv
module bk_adder_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0]  a8 = '0, b8 = '0;
    logic [15:0] aw = '0;
    logic [10:0] bw = '0;

    logic [8:0]  s8u, s8s;
    logic [6:0]  s6;
    logic [2:0]  s2;
    logic [16:0] swu, sws;

    bk_adder #(.WA(8),  .WB(8),  .SIGNED_MODE(1'b0)) uut    (.op_a(a8),      .op_b(b8),      .sum_o(s8u));
    bk_adder #(.WA(8),  .WB(8),  .SIGNED_MODE(1'b1)) uut_s  (.op_a(a8),      .op_b(b8),      .sum_o(s8s));
    bk_adder #(.WA(6),  .WB(6),  .SIGNED_MODE(1'b1)) uut_6  (.op_a(a8[5:0]), .op_b(b8[5:0]), .sum_o(s6));
    bk_adder #(.WA(2),  .WB(2),  .SIGNED_MODE(1'b1)) uut_2  (.op_a(a8[1:0]), .op_b(b8[1:0]), .sum_o(s2));
    bk_adder #(.WA(16), .WB(11), .SIGNED_MODE(1'b0)) uut_wu (.op_a(aw),      .op_b(bw),      .sum_o(swu));
    bk_adder #(.WA(16), .WB(11), .SIGNED_MODE(1'b1)) uut_ws (.op_a(aw),      .op_b(bw),      .sum_o(sws));

    typedef struct {
        logic [8:0]  e8u;
        logic [8:0]  e8s;
        logic [6:0]  e6;
        logic [2:0]  e2;
        logic [16:0] ewu;
        logic [16:0] ews;
        string       tag;
    } exp_t;

    exp_t sb[$];

    // Compare one value and log mismatches
    task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: apply a vector after the edge and queue the expected results
    task automatic drive(input logic [7:0] a, input logic [7:0] b,
                         input logic [15:0] wa, input logic [10:0] wb, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        a8 = a; b8 = b; aw = wa; bw = wb;
        e.e8u = {1'b0, a} + {1'b0, b};
        e.e8s = {a[7], a} + {b[7], b};
        e.e6  = {a[5], a[5:0]} + {b[5], b[5:0]};
        e.e2  = {a[1], a[1:0]} + {b[1], b[1:0]};
        e.ewu = {1'b0, wa} + {6'b0, wb};
        e.ews = {wa[15], wa} + {{6{wb[10]}}, wb};
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: settle at the falling edge and score every instance
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() != 0) begin
                exp_t e;
                e = sb.pop_front();
                chk({"R1 unsigned8 ", e.tag}, {8'b0, s8u}, {8'b0, e.e8u});
                chk({"R2 signed8 ", e.tag},   {8'b0, s8s}, {8'b0, e.e8s});
                chk({"R5 signed6 ", e.tag},   {10'b0, s6}, {10'b0, e.e6});
                chk({"R8 signed2 ", e.tag},   {14'b0, s2}, {14'b0, e.e2});
                chk({"R3 unsigned16x11 ", e.tag}, swu, e.ewu);
                chk({"R3 signed16x11 ", e.tag},   sws, e.ews);
            end
        end
    end

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1 actual=running expected=done");
        report();
    end

    // Stimulus
    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R4: all-zero operands give zero in every instance
        drive(8'h00, 8'h00, 16'h0000, 11'h000, "R4 zeros");
        // R6: all-ones plus one ripples across every column
        drive(8'hFF, 8'h01, 16'hFFFF, 11'h001, "R6 full ripple");
        drive(8'h01, 8'hFF, 16'h0001, 11'h7FF, "R6 ripple swapped");
        // R7: most-negative operands
        drive(8'h80, 8'h80, 16'h8000, 11'h400, "R7 most negative");
        // R3: narrow operand negative in signed mode, zero-filled in unsigned
        drive(8'h7F, 8'h7F, 16'h0001, 11'h7FF, "R3 sign fill");
        drive(8'hFF, 8'hFF, 16'hFFFF, 11'h7FF, "R3 all ones");
        // R1 R2 R5 R8: exhaustive small widths, random wide widths
        for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < 256; ib++) begin
                drive(ia[7:0], ib[7:0], 16'($urandom), 11'($urandom), "sweep");
            end
        end
        repeat (3) @(posedge clk);
        report();
    end
endmodule